// File: doc/BRIEF.md
# Fault Physical-Address Register Access Resolver

This block guards one 64-bit system register that records the physical address of a faulting access. When software issues a system-register read or write, the block receives the decoded instruction fields, the direction, the current exception level and a bundle of control bits. It resolves them, in a fixed priority order, into a single outcome. The outcome is one of the following: no match, undefined instruction, trap to EL2, trap to EL3, redirection to a memory slot at a fixed offset, access to the local EL1 register, or access to its EL2 counterpart. The block does not perform the memory access or the exception entry. It only reports them, together with a 6-bit syndrome class and the redirection offset.

Two encodings reach the register. The main accessor always exists. A second, aliased accessor exists only when the host-extension option is built in, and it is resolved under its own rules. The block also holds the register store. A fault-capture strobe loads the address and the address-space bits and sets a valid flag. A software write that resolves to a local access overwrites the stored value. Reserved bits, and address bits above the implemented width, are always cleared.

Top module: `fault_pa_access`

## Requirements
- R1: A request sampled with `req_valid` high at a rising edge produces `rsp_valid` high, with the outcome, syndrome, offset and read data, during the following clock cycle only.
- R2: The main encoding is op0=3, op1=0, CRn=6, CRm=0, op2=5. The alias encoding differs only in op1=5. Any other encoding gives outcome code 0 (no match). Outcome codes: 1 undefined, 2 trap EL2, 3 trap EL3, 4 memory redirect, 5 EL1 register access, 6 EL2 counterpart access.
- R3: A matching access from EL0 is undefined. When the feature is not built in (`FEAT_PRESENT`=0), every matching access is undefined.
- R4: The main accessor at EL1 is resolved in this order:
  - If the EL3 gate is closed and the undefined-priority condition holds, the access is undefined.
  - If EL2 is enabled with fine-grained traps present, and either the EL3 fine-grained enable is 0 or the direction's allow bit is 0, the access traps to EL2.
  - If the EL3 gate is closed, the access is undefined when the undefined-select bit is 1 and traps to EL3 otherwise.
  - If the nested-virtualization bits equal 111, the access is redirected to memory.
  - Otherwise it reaches the EL1 register.
- R5: Reads consult only `ctl_fgt_rd_ok` and writes consult only `ctl_fgt_wr_ok`.
- R6: Both trap outcomes report syndrome class 0x18. Every other outcome reports 0.
- R7: The main accessor at EL2 applies only the EL3 checks of R4 and ignores the fine-grained and nested-virtualization bits. It then reaches the EL2 counterpart in host mode and the EL1 register otherwise. At EL3 it reaches the EL1 register.
- R8: The alias accessor at EL1 is redirected to memory when the nested-virtualization bits equal 101. Otherwise it traps to EL2 when bit 0 of those bits is 1, and is undefined in the remaining cases.
- R9: The alias accessor at EL2 is undefined outside host mode. In host mode it passes the EL3 checks and then reaches the EL1 register. At EL3 it reaches the EL1 register in host mode and is undefined otherwise.
- R10: `rsp_nv_offset` is 0x2D0 for a memory-redirect outcome and 0 otherwise.
- R11: A fault strobe sets the valid flag and loads `flt_pa` into bits 51:0 and `flt_space` {NSE,NS} into bits 62:63. Space codes are 00 Secure, 01 Non-secure, 10 reserved and 11 Realm. The strobe wins over a software write in the same cycle.
- R12: Stored bits 61:56, and bits 55:`PA_BITS` (55:52 by default), are always zero after a capture or a write.
- R13: A write changes the store only on outcome 5, and it leaves the valid flag unchanged. A read returns the stored value on outcome 5 and 0 on every other outcome.
- R14: After reset, `rsp_valid` and `reg_valid` are 0 and the store holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_op0 | input | 2 | Instruction op0 field |
| req_op1 | input | 3 | Instruction op1 field |
| req_crn | input | 4 | Instruction CRn field |
| req_crm | input | 4 | Instruction CRm field |
| req_op2 | input | 3 | Instruction op2 field |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 64 | Write data |
| req_el | input | 2 | Current exception level |
| ctl_el2_en | input | 1 | EL2 enabled in current state |
| ctl_el2_host | input | 1 | EL2 in host mode |
| ctl_el3_gate | input | 1 | EL3 access enable for this register |
| ctl_el3_fgt_en | input | 1 | EL3 enable of fine-grained trap set 2 |
| ctl_fgt_rd_ok | input | 1 | Read allow bit (0 traps) |
| ctl_fgt_wr_ok | input | 1 | Write allow bit (0 traps) |
| ctl_undef_prio | input | 1 | Undefined takes priority when EL3 gate closed |
| ctl_undef_sel | input | 1 | Closed EL3 gate gives undefined instead of trap |
| ctl_nv | input | 3 | Nested-virtualization bits |
| flt_strobe | input | 1 | Fault capture strobe |
| flt_pa | input | 56 | Faulting physical address |
| flt_space | input | 2 | Address space {NSE,NS} |
| rsp_valid | output | 1 | Response valid |
| rsp_outcome | output | 3 | Outcome code |
| rsp_syndrome | output | 6 | Syndrome class for traps |
| rsp_nv_offset | output | 12 | Memory redirect offset |
| rsp_rdata | output | 64 | Read data |
| reg_value | output | 64 | Stored register value |
| reg_valid | output | 1 | Stored value is valid |

## Verification
The embedded properties assume that the request fields, the control bits and the fault inputs are stable and known at every rising edge that reset does not cover. They also assume that the outcome depends only on the values present at the edge where `req_valid` is high. The bench changes every input only at falling edges and drops `req_valid` after one cycle, so each request is resolved against one settled control set. Collisions between a fault strobe and a software write are produced deliberately within a single cycle to check the priority.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  typedef enum logic [2:0] {
    OC_NOMATCH = 3'd0,
    OC_UNDEF   = 3'd1,
    OC_TRAP2   = 3'd2,
    OC_TRAP3   = 3'd3,
    OC_NVMEM   = 3'd4,
    OC_LOCAL   = 3'd5,
    OC_EL2REG  = 3'd6
  } fpa_outcome_t;

  typedef struct packed {
    logic       el2_en;
    logic       el2_host;
    logic       el3_gate;
    logic       el3_fgt_en;
    logic       fgt_rd_ok;
    logic       fgt_wr_ok;
    logic       undef_prio;
    logic       undef_sel;
    logic [2:0] nv;
  } fpa_ctl_t;

  localparam logic [5:0]  TRAP_CLASS = 6'h18;
  localparam logic [11:0] NV_SLOT    = 12'h2D0;

endpackage

// File: rtl/fpa_decode.sv
module fpa_decode #(
  parameter int ALIAS_PRESENT = 1
) (
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit_main,
  output logic       hit_alias
);
  logic common_ok;

  always_comb begin
    common_ok = (op0 == 2'b11) && (crn == 4'b0110) && (crm == 4'b0000) && (op2 == 3'b101);
    hit_main  = common_ok && (op1 == 3'b000);
  end

  generate
    if (ALIAS_PRESENT != 0) begin : g_alias
      always_comb hit_alias = common_ok && (op1 == 3'b101);
    end else begin : g_no_alias
      always_comb hit_alias = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fpa_resolve.sv
module fpa_resolve
  import fpa_pkg::*;
#(
  parameter int FEAT_PRESENT = 1,
  parameter int EL3_PRESENT  = 1,
  parameter int FGT2_PRESENT = 1
) (
  input  logic         hit_main,
  input  logic         hit_alias,
  input  logic         is_write,
  input  logic [1:0]   el,
  input  fpa_ctl_t     ctl,
  output fpa_outcome_t outcome
);
  localparam logic HAS_FEAT = (FEAT_PRESENT != 0);
  localparam logic HAS_EL3  = (EL3_PRESENT != 0);
  localparam logic HAS_FGT2 = (FGT2_PRESENT != 0);

  logic         gate_undef_first;
  logic         gate_closed;
  fpa_outcome_t gate_result;
  logic         fgt_allow;
  logic         fgt_trap;

  always_comb begin
    gate_undef_first = HAS_EL3 && ctl.undef_prio && !ctl.el3_gate;
    gate_closed      = HAS_EL3 && !ctl.el3_gate;
    gate_result      = ctl.undef_sel ? OC_UNDEF : OC_TRAP3;
    fgt_allow        = is_write ? ctl.fgt_wr_ok : ctl.fgt_rd_ok;
    fgt_trap         = ctl.el2_en && HAS_FGT2 && ((HAS_EL3 && !ctl.el3_fgt_en) || !fgt_allow);
  end

  always_comb begin
    outcome = OC_NOMATCH;
    if (!hit_main && !hit_alias) begin
      outcome = OC_NOMATCH;
    end else if (!HAS_FEAT || el == 2'd0) begin
      outcome = OC_UNDEF;
    end else if (hit_main) begin
      case (el)
        2'd1: begin
          if (gate_undef_first)     outcome = OC_UNDEF;
          else if (fgt_trap)        outcome = OC_TRAP2;
          else if (gate_closed)     outcome = gate_result;
          else if (ctl.nv == 3'b111) outcome = OC_NVMEM;
          else                      outcome = OC_LOCAL;
        end
        2'd2: begin
          if (gate_undef_first)     outcome = OC_UNDEF;
          else if (gate_closed)     outcome = gate_result;
          else if (ctl.el2_host)    outcome = OC_EL2REG;
          else                      outcome = OC_LOCAL;
        end
        default: outcome = OC_LOCAL;
      endcase
    end else begin
      case (el)
        2'd1: begin
          if (ctl.nv == 3'b101)     outcome = OC_NVMEM;
          else if (ctl.nv[0])       outcome = OC_TRAP2;
          else                      outcome = OC_UNDEF;
        end
        2'd2: begin
          if (!ctl.el2_host)        outcome = OC_UNDEF;
          else if (gate_undef_first) outcome = OC_UNDEF;
          else if (gate_closed)     outcome = gate_result;
          else                      outcome = OC_LOCAL;
        end
        default: outcome = ctl.el2_host ? OC_LOCAL : OC_UNDEF;
      endcase
    end
  end
endmodule

// File: rtl/fpa_store.sv
module fpa_store #(
  parameter int PA_BITS      = 52,
  parameter int REALM_PRESENT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic [55:0] cap_pa,
  input  logic [1:0]  cap_space,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  output logic [63:0] value,
  output logic        valid
);
  localparam logic [63:0] PA_KEEP    = (64'd1 << PA_BITS) - 64'd1;
  localparam logic [63:0] NSE_KEEP   = (REALM_PRESENT != 0) ? (64'd1 << 62) : 64'd0;
  localparam logic [63:0] KEEP_MASK  = PA_KEEP | NSE_KEEP | (64'd1 << 63);

  logic [63:0] value_q, value_d;
  logic        valid_q, valid_d;
  logic        load_en;

  always_comb begin
    load_en = cap_en || wr_en;
    valid_d = valid_q;
    value_d = value_q;
    if (cap_en) begin
      value_d = {cap_space[0], cap_space[1], 6'b0, cap_pa} & KEEP_MASK;
      valid_d = 1'b1;
    end else if (wr_en) begin
      value_d = wr_data & KEEP_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      valid_q <= 1'b0;
    end else if (load_en) begin
      value_q <= value_d;
      valid_q <= valid_d;
    end
  end

  assign value = value_q;
  assign valid = valid_q;

  assert_capture_sets_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> valid_q);

  assert_capture_loads_pa_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (value_q[47:0] == $past(cap_pa[47:0])) && (value_q[63] == $past(cap_space[0])));

  assert_idle_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !wr_en) |=> ($stable(value_q) && $stable(valid_q)));

  assert_write_keeps_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cap_en) |=> $stable(valid_q));
endmodule

// File: rtl/fault_pa_access.sv
module fault_pa_access
  import fpa_pkg::*;
#(
  parameter int FEAT_PRESENT  = 1,
  parameter int ALIAS_PRESENT = 1,
  parameter int EL3_PRESENT   = 1,
  parameter int FGT2_PRESENT  = 1,
  parameter int REALM_PRESENT = 1,
  parameter int PA_BITS       = 52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op0,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic        req_write,
  input  logic [63:0] req_wdata,
  input  logic [1:0]  req_el,
  input  logic        ctl_el2_en,
  input  logic        ctl_el2_host,
  input  logic        ctl_el3_gate,
  input  logic        ctl_el3_fgt_en,
  input  logic        ctl_fgt_rd_ok,
  input  logic        ctl_fgt_wr_ok,
  input  logic        ctl_undef_prio,
  input  logic        ctl_undef_sel,
  input  logic [2:0]  ctl_nv,
  input  logic        flt_strobe,
  input  logic [55:0] flt_pa,
  input  logic [1:0]  flt_space,
  output logic        rsp_valid,
  output logic [2:0]  rsp_outcome,
  output logic [5:0]  rsp_syndrome,
  output logic [11:0] rsp_nv_offset,
  output logic [63:0] rsp_rdata,
  output logic [63:0] reg_value,
  output logic        reg_valid
);
  fpa_ctl_t     ctl;
  logic         hit_main, hit_alias;
  fpa_outcome_t outcome;
  logic         wr_commit;

  logic         rsp_valid_q, rsp_valid_d;
  fpa_outcome_t rsp_oc_q, rsp_oc_d;
  logic [5:0]   rsp_syn_q, rsp_syn_d;
  logic [11:0]  rsp_off_q, rsp_off_d;
  logic [63:0]  rsp_rd_q, rsp_rd_d;

  always_comb begin
    ctl.el2_en     = ctl_el2_en;
    ctl.el2_host   = ctl_el2_host;
    ctl.el3_gate   = ctl_el3_gate;
    ctl.el3_fgt_en = ctl_el3_fgt_en;
    ctl.fgt_rd_ok  = ctl_fgt_rd_ok;
    ctl.fgt_wr_ok  = ctl_fgt_wr_ok;
    ctl.undef_prio = ctl_undef_prio;
    ctl.undef_sel  = ctl_undef_sel;
    ctl.nv         = ctl_nv;
  end

  fpa_decode #(.ALIAS_PRESENT(ALIAS_PRESENT)) u_decode (
    .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
    .hit_main(hit_main), .hit_alias(hit_alias)
  );

  fpa_resolve #(
    .FEAT_PRESENT(FEAT_PRESENT), .EL3_PRESENT(EL3_PRESENT), .FGT2_PRESENT(FGT2_PRESENT)
  ) u_resolve (
    .hit_main(hit_main), .hit_alias(hit_alias), .is_write(req_write),
    .el(req_el), .ctl(ctl), .outcome(outcome)
  );

  always_comb begin
    wr_commit   = req_valid && req_write && (outcome == OC_LOCAL);
    rsp_valid_d = req_valid;
    rsp_oc_d    = rsp_oc_q;
    rsp_syn_d   = rsp_syn_q;
    rsp_off_d   = rsp_off_q;
    rsp_rd_d    = rsp_rd_q;
    if (req_valid) begin
      rsp_oc_d  = outcome;
      rsp_syn_d = (outcome == OC_TRAP2 || outcome == OC_TRAP3) ? TRAP_CLASS : 6'd0;
      rsp_off_d = (outcome == OC_NVMEM) ? NV_SLOT : 12'd0;
      rsp_rd_d  = (!req_write && outcome == OC_LOCAL) ? reg_value : 64'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_oc_q    <= OC_NOMATCH;
      rsp_syn_q   <= '0;
      rsp_off_q   <= '0;
      rsp_rd_q    <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (req_valid) begin
        rsp_oc_q  <= rsp_oc_d;
        rsp_syn_q <= rsp_syn_d;
        rsp_off_q <= rsp_off_d;
        rsp_rd_q  <= rsp_rd_d;
      end
    end
  end

  fpa_store #(.PA_BITS(PA_BITS), .REALM_PRESENT(REALM_PRESENT)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cap_en(flt_strobe), .cap_pa(flt_pa), .cap_space(flt_space),
    .wr_en(wr_commit), .wr_data(req_wdata),
    .value(reg_value), .valid(reg_valid)
  );

  assign rsp_valid     = rsp_valid_q;
  assign rsp_outcome   = rsp_oc_q;
  assign rsp_syndrome  = rsp_syn_q;
  assign rsp_nv_offset = rsp_off_q;
  assign rsp_rdata     = rsp_rd_q;

  assert_req_gives_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_req_no_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_el0_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_el == 2'd0 && req_op0 == 2'b11 && req_crn == 4'b0110 &&
     req_crm == 4'b0000 && req_op2 == 3'b101 && req_op1 == 3'b000)
    |=> (rsp_outcome == OC_UNDEF));

  assert_trap_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_outcome == OC_TRAP2 || rsp_outcome == OC_TRAP3)) |-> (rsp_syndrome == 6'h18));

  assert_nomatch_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op2 != 3'b101 && !flt_strobe) |=> $stable(reg_value));
endmodule

// File: tb/test_fault_pa_access.sv
`timescale 1ns/1ps
module test_fault_pa_access;
  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_op0, req_el;
  logic [2:0]  req_op1, req_op2;
  logic [3:0]  req_crn, req_crm;
  logic [63:0] req_wdata;
  logic        ctl_el2_en, ctl_el2_host, ctl_el3_gate, ctl_el3_fgt_en;
  logic        ctl_fgt_rd_ok, ctl_fgt_wr_ok, ctl_undef_prio, ctl_undef_sel;
  logic [2:0]  ctl_nv;
  logic        flt_strobe;
  logic [55:0] flt_pa;
  logic [1:0]  flt_space;
  logic        rsp_valid, reg_valid;
  logic [2:0]  rsp_outcome;
  logic [5:0]  rsp_syndrome;
  logic [11:0] rsp_nv_offset;
  logic [63:0] rsp_rdata, reg_value;
  logic        nf_rsp_valid, nf_reg_valid;
  logic [2:0]  nf_rsp_outcome;
  logic [5:0]  nf_rsp_syndrome;
  logic [11:0] nf_rsp_nv_offset;
  logic [63:0] nf_rsp_rdata, nf_reg_value;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  localparam logic [2:0] MAIN = 3'd0;
  localparam logic [2:0] ALIAS = 3'd5;

  fault_pa_access i_fault_pa_access (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op0(req_op0), .req_op1(req_op1),
    .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2), .req_write(req_write),
    .req_wdata(req_wdata), .req_el(req_el), .ctl_el2_en(ctl_el2_en), .ctl_el2_host(ctl_el2_host),
    .ctl_el3_gate(ctl_el3_gate), .ctl_el3_fgt_en(ctl_el3_fgt_en), .ctl_fgt_rd_ok(ctl_fgt_rd_ok),
    .ctl_fgt_wr_ok(ctl_fgt_wr_ok), .ctl_undef_prio(ctl_undef_prio), .ctl_undef_sel(ctl_undef_sel),
    .ctl_nv(ctl_nv), .flt_strobe(flt_strobe), .flt_pa(flt_pa), .flt_space(flt_space),
    .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_syndrome(rsp_syndrome),
    .rsp_nv_offset(rsp_nv_offset), .rsp_rdata(rsp_rdata), .reg_value(reg_value), .reg_valid(reg_valid)
  );

  fault_pa_access #(.FEAT_PRESENT(0)) i_fault_pa_access_nofeat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op0(req_op0), .req_op1(req_op1),
    .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2), .req_write(req_write),
    .req_wdata(req_wdata), .req_el(req_el), .ctl_el2_en(ctl_el2_en), .ctl_el2_host(ctl_el2_host),
    .ctl_el3_gate(ctl_el3_gate), .ctl_el3_fgt_en(ctl_el3_fgt_en), .ctl_fgt_rd_ok(ctl_fgt_rd_ok),
    .ctl_fgt_wr_ok(ctl_fgt_wr_ok), .ctl_undef_prio(ctl_undef_prio), .ctl_undef_sel(ctl_undef_sel),
    .ctl_nv(ctl_nv), .flt_strobe(flt_strobe), .flt_pa(flt_pa), .flt_space(flt_space),
    .rsp_valid(nf_rsp_valid), .rsp_outcome(nf_rsp_outcome), .rsp_syndrome(nf_rsp_syndrome),
    .rsp_nv_offset(nf_rsp_nv_offset), .rsp_rdata(nf_rsp_rdata), .reg_value(nf_reg_value),
    .reg_valid(nf_reg_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ctl_open();
    ctl_el2_en = 1'b1; ctl_el2_host = 1'b0; ctl_el3_gate = 1'b1; ctl_el3_fgt_en = 1'b1;
    ctl_fgt_rd_ok = 1'b1; ctl_fgt_wr_ok = 1'b1; ctl_undef_prio = 1'b0; ctl_undef_sel = 1'b0;
    ctl_nv = 3'b000;
  endtask

  // one request, inputs changed at falling edges; outputs sampled one cycle later
  task automatic access(input logic [2:0] op1, input logic [1:0] el, input logic wr,
                        input logic [63:0] wd, input logic [2:0] op2 = 3'b101);
    @(negedge clk);
    req_valid = 1'b1; req_op0 = 2'b11; req_op1 = op1; req_crn = 4'b0110; req_crm = 4'b0000;
    req_op2 = op2; req_el = el; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_oc(input string tag, input logic [2:0] exp_oc);
    check({tag, " valid"}, {63'd0, rsp_valid}, 64'd1);
    check({tag, " outcome"}, {61'd0, rsp_outcome}, {61'd0, exp_oc});
    check({tag, " syndrome"}, {58'd0, rsp_syndrome},
          (exp_oc == 3'd2 || exp_oc == 3'd3) ? 64'h18 : 64'h0);
  endtask

  task automatic t_reset();
    check("R14 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    check("R14 reg_valid after reset", {63'd0, reg_valid}, 64'd0);
    check("R14 store after reset", reg_value, 64'd0);
  endtask

  task automatic t_decode();
    ctl_open();
    access(MAIN, 2'd3, 1'b0, 64'd0, 3'b100);
    expect_oc("R2 other encoding", 3'd0);
    access(MAIN, 2'd3, 1'b0, 64'd0);
    expect_oc("R2 main at EL3", 3'd5);
    @(negedge clk);
    check("R1 single-cycle response", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_el0();
    ctl_open();
    access(MAIN, 2'd0, 1'b0, 64'd0);
    expect_oc("R3 EL0 main", 3'd1);
    access(ALIAS, 2'd0, 1'b0, 64'd0);
    expect_oc("R3 EL0 alias", 3'd1);
    access(MAIN, 2'd1, 1'b0, 64'd0);
    check("R3 no-feature outcome", {61'd0, nf_rsp_outcome}, 64'd1);
  endtask

  task automatic t_store();
    ctl_open();
    access(MAIN, 2'd3, 1'b1, '1);
    expect_oc("R13 write EL3", 3'd5);
    check("R12 write masked", reg_value, 64'hC00F_FFFF_FFFF_FFFF);
    check("R13 write keeps valid 0", {63'd0, reg_valid}, 64'd0);
    access(MAIN, 2'd3, 1'b0, 64'd0);
    check("R13 read back", rsp_rdata, 64'hC00F_FFFF_FFFF_FFFF);
    @(negedge clk);
    flt_strobe = 1'b1; flt_pa = 56'hAB_CDEF_0123_4567; flt_space = 2'b11;
    @(negedge clk);
    flt_strobe = 1'b0;
    check("R11 capture value", reg_value, {flt_space[0], flt_space[1], 6'd0, 4'd0, flt_pa[51:0]});
    check("R11 capture valid", {63'd0, reg_valid}, 64'd1);
    ctl_el3_gate = 1'b0;
    access(MAIN, 2'd1, 1'b1, 64'h1234);
    expect_oc("R13 blocked write", 3'd3);
    check("R13 blocked write leaves store", reg_value, 64'hC00B_CDEF_0123_4567);
    access(MAIN, 2'd1, 1'b0, 64'd0);
    check("R13 trapped read data", rsp_rdata, 64'd0);
    ctl_open();
    @(negedge clk);
    flt_strobe = 1'b1; flt_pa = 56'h00_0000_0000_1000; flt_space = 2'b01;
    req_valid = 1'b1; req_op0 = 2'b11; req_op1 = MAIN; req_crn = 4'b0110; req_crm = 4'b0000;
    req_op2 = 3'b101; req_el = 2'd3; req_write = 1'b1; req_wdata = '1;
    @(negedge clk);
    flt_strobe = 1'b0; req_valid = 1'b0;
    check("R11 capture beats write", reg_value, 64'h8000_0000_0000_1000);
  endtask

  task automatic t_el1_order();
    ctl_open();
    access(MAIN, 2'd1, 1'b0, 64'd0);
    expect_oc("R4 all open", 3'd5);
    ctl_el3_gate = 1'b0; ctl_undef_prio = 1'b1; ctl_fgt_rd_ok = 1'b0;
    access(MAIN, 2'd1, 1'b0, 64'd0);
    expect_oc("R4 undef-first beats fgt", 3'd1);
    ctl_undef_prio = 1'b0;
    access(MAIN, 2'd1, 1'b0, 64'd0);
    expect_oc("R4 fgt beats gate", 3'd2);
    ctl_fgt_rd_ok = 1'b1;
    access(MAIN, 2'd1, 1'b0, 64'd0);
    expect_oc("R4 gate trap EL3", 3'd3);
    ctl_undef_sel = 1'b1;
    access(MAIN, 2'd1, 1'b0, 64'd0);
    expect_oc("R4 gate undef", 3'd1);
    ctl_open(); ctl_nv = 3'b111;
    access(MAIN, 2'd1, 1'b0, 64'd0);
    expect_oc("R4 nv redirect", 3'd4);
    check("R10 offset", {52'd0, rsp_nv_offset}, 64'h2D0);
    ctl_el3_fgt_en = 1'b0;
    access(MAIN, 2'd1, 1'b0, 64'd0);
    expect_oc("R4 el3 fgt enable off", 3'd2);
    ctl_el2_en = 1'b0;
    access(MAIN, 2'd1, 1'b0, 64'd0);
    expect_oc("R4 el2 off skips fgt", 3'd4);
    ctl_nv = 3'b000;
    access(MAIN, 2'd1, 1'b0, 64'd0);
    check("R10 offset zero", {52'd0, rsp_nv_offset}, 64'd0);
  endtask

  task automatic t_direction();
    ctl_open(); ctl_fgt_rd_ok = 1'b0;
    access(MAIN, 2'd1, 1'b0, 64'd0);
    expect_oc("R5 read uses rd bit", 3'd2);
    access(MAIN, 2'd1, 1'b1, 64'd0);
    expect_oc("R5 write ignores rd bit", 3'd5);
    ctl_fgt_rd_ok = 1'b1; ctl_fgt_wr_ok = 1'b0;
    access(MAIN, 2'd1, 1'b1, 64'd0);
    expect_oc("R5 write uses wr bit", 3'd2);
    access(MAIN, 2'd1, 1'b0, 64'd0);
    expect_oc("R5 read ignores wr bit", 3'd5);
  endtask

  task automatic t_el2_main();
    ctl_open(); ctl_el2_host = 1'b1;
    access(MAIN, 2'd2, 1'b0, 64'd0);
    expect_oc("R7 host EL2 reg", 3'd6);
    ctl_el2_host = 1'b0; ctl_fgt_rd_ok = 1'b0; ctl_nv = 3'b111;
    access(MAIN, 2'd2, 1'b0, 64'd0);
    expect_oc("R7 non-host ignores fgt nv", 3'd5);
    ctl_el3_gate = 1'b0;
    access(MAIN, 2'd2, 1'b0, 64'd0);
    expect_oc("R7 gate trap EL3", 3'd3);
  endtask

  task automatic t_alias();
    ctl_open(); ctl_nv = 3'b101;
    access(ALIAS, 2'd1, 1'b0, 64'd0);
    expect_oc("R8 nv 101 redirect", 3'd4);
    check("R10 alias offset", {52'd0, rsp_nv_offset}, 64'h2D0);
    ctl_nv = 3'b111;
    access(ALIAS, 2'd1, 1'b0, 64'd0);
    expect_oc("R8 nv 111 trap", 3'd2);
    ctl_nv = 3'b110;
    access(ALIAS, 2'd1, 1'b0, 64'd0);
    expect_oc("R8 nv 110 undef", 3'd1);
    ctl_open(); ctl_el2_host = 1'b1;
    access(ALIAS, 2'd2, 1'b0, 64'd0);
    expect_oc("R9 EL2 host", 3'd5);
    ctl_el3_gate = 1'b0;
    access(ALIAS, 2'd2, 1'b0, 64'd0);
    expect_oc("R9 EL2 host gate", 3'd3);
    ctl_open();
    access(ALIAS, 2'd2, 1'b0, 64'd0);
    expect_oc("R9 EL2 non-host", 3'd1);
    access(ALIAS, 2'd3, 1'b0, 64'd0);
    expect_oc("R9 EL3 non-host", 3'd1);
    ctl_el2_host = 1'b1;
    access(ALIAS, 2'd3, 1'b0, 64'd0);
    expect_oc("R9 EL3 host", 3'd5);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_op0 = '0; req_op1 = '0;
    req_op2 = '0; req_crn = '0; req_crm = '0; req_el = '0; req_wdata = '0;
    flt_strobe = 1'b0; flt_pa = '0; flt_space = '0;
    ctl_open();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_el0();
    t_store();
    t_el1_order();
    t_direction();
    t_el2_main();
    t_alias();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule